// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a parallel LCD panel. It works from the system clock and divides it by a programmable amount to form the pixel shift clock. Every shift-clock period is one horizontal position. Each line has four parts in order: the visible pixels, a front wait, the line sync pulse and a back wait. A frame is built from lines in the same way: visible lines, a front wait, the frame sync and a back wait. Every part is set by its own configuration field. A zero-length part is skipped.

The outputs are the line sync, frame sync, output enable and shift clock. The block also reports the current pixel coordinates and gives a one-cycle pulse on the first and on the last visible pixel of a frame. The line sync, the frame sync and the shift clock each have a polarity input. The shift clock can be parked at its idle level for the whole frame sync interval. Configuration inputs are sampled live. A region that is made shorter than the current position ends on the next step.

Top module: `lcdt_raster`

## Requirements
- R1: One shift-clock period lasts `cfg_div`+1 system clocks, and every position counter advances once per period. With `cfg_div`=0 they advance on every system clock.
- R2: The shift-clock phase is high for floor((`cfg_div`+1)/2) system clocks from the start of each period and low for the rest of it. `lcd_sclk` equals that phase XOR `cfg_clkpol`.
- R3: A line holds W=16·`cfg_xmax16` visible positions, then `cfg_hfront` positions, then `cfg_hsw` positions of line sync, then `cfg_hback` positions, and then the next line starts.
- R4: A frame holds `cfg_ymax` visible lines, then `cfg_vfront` lines, then `cfg_vsw` lines of frame sync, then `cfg_vback` lines, and then the next frame starts.
- R5: `lcd_hsync` equals the internal line sync XOR `cfg_hpol`, and `lcd_vsync` equals the internal frame sync XOR `cfg_vpol`. A polarity value of 1 makes the signal active low.
- R6: When `cfg_sclk_run`=0, `lcd_sclk` stays at `cfg_clkpol` during every frame-sync line, and the timing counters keep running. When `cfg_sclk_run`=1, the shift clock keeps toggling during frame sync.
- R7: `lcd_oe` is 1 only when the horizontal position is below W and the line is below `cfg_ymax`. `pix_x` shows the horizontal position while `lcd_oe` is 1 and is 0 otherwise. `pix_y` shows the line while the line is visible and is 0 otherwise.
- R8: `frame_start` is high for one system clock, the last clock of the shift period of pixel (0,0). `frame_end` is high for the last clock of the shift period of pixel (W-1, `cfg_ymax`-1). The two are never high in the same cycle.
- R9: After reset the divider and both position counters are 0.
- R10: A counter whose position is at or beyond its current total returns to 0 on its next step. If the total is zero, the position stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 6 | Shift-clock divider, period = value+1 clocks |
| cfg_xmax16 | input | 6 | Visible width in units of 16 pixels |
| cfg_ymax | input | 10 | Visible height in lines |
| cfg_hsw | input | 6 | Line sync width in shift periods |
| cfg_hfront | input | 8 | Periods from end of visible pixels to line sync |
| cfg_hback | input | 8 | Periods from end of line sync to next line |
| cfg_vsw | input | 6 | Frame sync width in lines |
| cfg_vfront | input | 8 | Lines from last visible line to frame sync |
| cfg_vback | input | 8 | Lines from end of frame sync to first line |
| cfg_hpol | input | 1 | Line sync polarity, 1 = active low |
| cfg_vpol | input | 1 | Frame sync polarity, 1 = active low |
| cfg_clkpol | input | 1 | Shift-clock inversion |
| cfg_sclk_run | input | 1 | 1 = shift clock toggles during frame sync |
| lcd_hsync | output | 1 | Line sync |
| lcd_vsync | output | 1 | Frame sync |
| lcd_oe | output | 1 | Output enable, active high |
| lcd_sclk | output | 1 | Pixel shift clock |
| pix_x | output | 10 | Current visible column |
| pix_y | output | 10 | Current visible line |
| frame_start | output | 1 | Pulse on first visible pixel |
| frame_end | output | 1 | Pulse on last visible pixel |

## Verification
The line sync pulse falls inside the frame-sync lines, so during those lines the line sync and the shift-clock parking act in the same system clock. The bench sets up a two-line frame sync with a one-period line sync, inverted polarities and parking enabled. It then compares both outputs with its reference model on every clock, and it counts any shift-clock edge that occurs while the frame sync is active. A run with the same overlap and parking disabled must show such edges, so the parking is shown to depend on its mode input and not on the line sync.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    // Output shaping options applied after the timing counters
    typedef struct packed {
        logic hs_low;    // line sync active low
        logic vs_low;    // frame sync active low
        logic clk_inv;   // shift clock inverted
        logic clk_free;  // shift clock runs through frame sync
    } lcdt_shape_t;

    localparam int unsigned LCDT_PIX_PER_UNIT_LOG2 = 4;

endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
    parameter int unsigned DIVW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] div,
    output logic            tick,
    output logic            phase
);

    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DIVW:0] hi_len;

    always_comb begin
        st_d   = st_q;
        tick   = (st_q.cnt >= div);
        hi_len = ({1'b0, div} + 1'b1) >> 1;
        phase  = ({1'b0, st_q.cnt} < hi_len);
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DIV_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R1
    AST_DIV_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |-> tick); // R1

endmodule

// File: rtl/lcdt_span.sv
module lcdt_span #(
    parameter int unsigned CW  = 11,
    parameter int unsigned AW  = 10,
    parameter int unsigned W1W = 8,
    parameter int unsigned SW  = 6,
    parameter int unsigned W2W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic [AW-1:0]  act_len,
    input  logic [W1W-1:0] lead_gap,
    input  logic [SW-1:0]  sync_len,
    input  logic [W2W-1:0] tail_gap,
    output logic [CW-1:0]  pos,
    output logic           in_act,
    output logic           in_sync,
    output logic           at_last
);

    typedef struct packed {
        logic [CW-1:0] pos;
    } span_st_t;

    span_st_t st_d, st_q;
    logic [CW:0] b_act, b_sync, b_end, b_tot, pos_nx;

    always_comb begin
        st_d    = st_q;
        b_act   = {{(CW+1-AW){1'b0}}, act_len};
        b_sync  = b_act  + {{(CW+1-W1W){1'b0}}, lead_gap};
        b_end   = b_sync + {{(CW+1-SW){1'b0}}, sync_len};
        b_tot   = b_end  + {{(CW+1-W2W){1'b0}}, tail_gap};
        pos_nx  = {1'b0, st_q.pos} + 1'b1;
        at_last = (pos_nx >= b_tot);
        in_act  = ({1'b0, st_q.pos} < b_act);
        in_sync = ({1'b0, st_q.pos} >= b_sync) && ({1'b0, st_q.pos} < b_end);
        if (step) begin
            if (at_last) st_d.pos = '0;
            else         st_d.pos = pos_nx[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos = st_q.pos;

    AST_SPAN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_last) |=> (pos == '0)); // R10
    AST_SPAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pos)); // R1

endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster #(
    parameter int unsigned DIVW   = 6,
    parameter int unsigned XMW    = 6,
    parameter int unsigned YW     = 10,
    parameter int unsigned HSW_W  = 6,
    parameter int unsigned HWT_W  = 8,
    parameter int unsigned VSW_W  = 6,
    parameter int unsigned VWT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIVW-1:0]      cfg_div,
    input  logic [XMW-1:0]       cfg_xmax16,
    input  logic [YW-1:0]        cfg_ymax,
    input  logic [HSW_W-1:0]     cfg_hsw,
    input  logic [HWT_W-1:0]     cfg_hfront,
    input  logic [HWT_W-1:0]     cfg_hback,
    input  logic [VSW_W-1:0]     cfg_vsw,
    input  logic [VWT_W-1:0]     cfg_vfront,
    input  logic [VWT_W-1:0]     cfg_vback,
    input  logic                 cfg_hpol,
    input  logic                 cfg_vpol,
    input  logic                 cfg_clkpol,
    input  logic                 cfg_sclk_run,
    output logic                 lcd_hsync,
    output logic                 lcd_vsync,
    output logic                 lcd_oe,
    output logic                 lcd_sclk,
    output logic [XMW+3:0]       pix_x,
    output logic [YW-1:0]        pix_y,
    output logic                 frame_start,
    output logic                 frame_end
);
    import lcdt_pkg::*;

    localparam int unsigned PXW  = XMW + LCDT_PIX_PER_UNIT_LOG2;
    localparam int unsigned HMAX = (2**PXW - 1) + (2**HSW_W - 1) + 2 * (2**HWT_W - 1);
    localparam int unsigned VMAX = (2**YW - 1) + (2**VSW_W - 1) + 2 * (2**VWT_W - 1);
    localparam int unsigned HCW  = $clog2(HMAX + 1);
    localparam int unsigned VCW  = $clog2(VMAX + 1);

    lcdt_shape_t      shape;
    logic             tick, phase, gate;
    logic [PXW-1:0]   h_len;
    logic [HCW-1:0]   h_pos;
    logic [VCW-1:0]   v_pos;
    logic             h_act, h_sync, h_last;
    logic             v_act, v_sync, v_last;
    logic             first_px, last_px;

    assign shape = '{hs_low: cfg_hpol, vs_low: cfg_vpol,
                     clk_inv: cfg_clkpol, clk_free: cfg_sclk_run};
    assign h_len = {cfg_xmax16, {LCDT_PIX_PER_UNIT_LOG2{1'b0}}};

    lcdt_clkdiv #(.DIVW(DIVW)) u_div (
        .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick), .phase(phase)
    );

    lcdt_span #(.CW(HCW), .AW(PXW), .W1W(HWT_W), .SW(HSW_W), .W2W(HWT_W)) u_hspan (
        .clk(clk), .rst_n(rst_n), .step(tick), .act_len(h_len),
        .lead_gap(cfg_hfront), .sync_len(cfg_hsw), .tail_gap(cfg_hback),
        .pos(h_pos), .in_act(h_act), .in_sync(h_sync), .at_last(h_last)
    );

    lcdt_span #(.CW(VCW), .AW(YW), .W1W(VWT_W), .SW(VSW_W), .W2W(VWT_W)) u_vspan (
        .clk(clk), .rst_n(rst_n), .step(tick && h_last), .act_len(cfg_ymax),
        .lead_gap(cfg_vfront), .sync_len(cfg_vsw), .tail_gap(cfg_vback),
        .pos(v_pos), .in_act(v_act), .in_sync(v_sync), .at_last(v_last)
    );

    always_comb begin
        lcd_oe      = h_act && v_act;
        pix_x       = lcd_oe ? h_pos[PXW-1:0] : '0;
        pix_y       = v_act ? v_pos[YW-1:0] : '0;
        lcd_hsync   = h_sync ^ shape.hs_low;
        lcd_vsync   = v_sync ^ shape.vs_low;
        gate        = v_sync && !shape.clk_free;
        lcd_sclk    = (phase && !gate) ^ shape.clk_inv;
        first_px    = (h_pos == '0) && (v_pos == '0);
        last_px     = (({1'b0, h_pos} + 1'b1) == {{(HCW+1-PXW){1'b0}}, h_len}) &&
                      (({1'b0, v_pos} + 1'b1) == {{(VCW+1-YW){1'b0}}, cfg_ymax});
        frame_start = tick && lcd_oe && first_px;
        frame_end   = tick && lcd_oe && last_px;
    end

    // frame wrap is observed through u_vspan's own assertion
    logic unused_v_last;
    assign unused_v_last = v_last;

    AST_BOF_EOF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && frame_end)); // R8
    AST_OE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_oe |-> ({{(32-YW){1'b0}}, pix_y} < {{(32-YW){1'b0}}, cfg_ymax})); // R7
    AST_HSYNC_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        h_sync |-> !lcd_oe); // R3
    AST_VSYNC_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        v_sync |-> !lcd_oe); // R4
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && $past(gate) && $stable(cfg_clkpol)) |-> $stable(lcd_sclk)); // R6

endmodule

// File: tb/lcdt_raster_bench.sv
`timescale 1ns/1ps
module lcdt_raster_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_div = '0, cfg_xmax16 = '0, cfg_hsw = '0, cfg_vsw = '0;
    logic [9:0]  cfg_ymax = '0;
    logic [7:0]  cfg_hfront = '0, cfg_hback = '0, cfg_vfront = '0, cfg_vback = '0;
    logic        cfg_hpol = 1'b0, cfg_vpol = 1'b0, cfg_clkpol = 1'b0, cfg_sclk_run = 1'b1;
    logic        lcd_hsync, lcd_vsync, lcd_oe, lcd_sclk, frame_start, frame_end;
    logic [9:0]  pix_x, pix_y;

    int checks = 0, failures = 0, cyc = 0;
    int m_cnt = 0, m_h = 0, m_v = 0;
    bit mon_on = 1'b0;
    int bof_q[$];
    int eof_n = 0, oe_n = 0, hs_n = 0, vs_tog = 0;
    logic prev_sclk = 1'b0;

    always #4 clk = ~clk;

    lcdt_raster u_lcdt_raster (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_xmax16(cfg_xmax16),
        .cfg_ymax(cfg_ymax), .cfg_hsw(cfg_hsw), .cfg_hfront(cfg_hfront),
        .cfg_hback(cfg_hback), .cfg_vsw(cfg_vsw), .cfg_vfront(cfg_vfront),
        .cfg_vback(cfg_vback), .cfg_hpol(cfg_hpol), .cfg_vpol(cfg_vpol),
        .cfg_clkpol(cfg_clkpol), .cfg_sclk_run(cfg_sclk_run),
        .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_oe(lcd_oe),
        .lcd_sclk(lcd_sclk), .pix_x(pix_x), .pix_y(pix_y),
        .frame_start(frame_start), .frame_end(frame_end)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: raster walk in integers
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_h = 0; m_v = 0;
        end else begin
            int htot, vtot;
            htot = 16 * cfg_xmax16 + cfg_hfront + cfg_hsw + cfg_hback;
            vtot = cfg_ymax + cfg_vfront + cfg_vsw + cfg_vback;
            if (m_cnt >= cfg_div) begin
                m_cnt = 0;
                if (m_h + 1 >= htot) begin
                    m_h = 0;
                    if (m_v + 1 >= vtot) m_v = 0;
                    else m_v++;
                end else m_h++;
            end else m_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && mon_on) begin
            int w, hh, e_x, e_y;
            bit tk, hact, vact, hs, vs, oe, ph;
            w  = 16 * cfg_xmax16; hh = cfg_ymax;
            tk = (m_cnt >= cfg_div);
            hact = (m_h < w); vact = (m_v < hh); oe = hact && vact;
            hs = (m_h >= w + cfg_hfront) && (m_h < w + cfg_hfront + cfg_hsw);
            vs = (m_v >= hh + cfg_vfront) && (m_v < hh + cfg_vfront + cfg_vsw);
            e_x = oe ? m_h : 0;
            e_y = vact ? m_v : 0;
            ph = (m_cnt < (cfg_div + 1) / 2);
            if (vs && !cfg_sclk_run) ph = 1'b0;
            chk("R7 oe", lcd_oe, oe);
            chk("R7 x", pix_x, e_x);
            chk("R7 y", pix_y, e_y);
            chk("R3/R5 hsync", lcd_hsync, hs ^ cfg_hpol);
            chk("R4/R5 vsync", lcd_vsync, vs ^ cfg_vpol);
            chk("R2/R6 sclk", lcd_sclk, ph ^ cfg_clkpol);
            chk("R8 bof", frame_start, tk && oe && m_h == 0 && m_v == 0);
            chk("R8 eof", frame_end, tk && oe && m_h == w - 1 && m_v == hh - 1);
            if (frame_start) bof_q.push_back(cyc);
            if (frame_end) eof_n++;
            if (lcd_oe) oe_n++;
            if (lcd_hsync ^ cfg_hpol) hs_n++;
            if ((lcd_vsync ^ cfg_vpol) && lcd_sclk != prev_sclk) vs_tog++;
            prev_sclk = lcd_sclk;
        end
    end

    task automatic setcfg(input int dv, input int xm, input int ym,
                          input int hf, input int hw, input int hb,
                          input int vf, input int vw, input int vb,
                          input bit hp, input bit vp, input bit cp, input bit run);
        cfg_div = dv[5:0]; cfg_xmax16 = xm[5:0]; cfg_ymax = ym[9:0];
        cfg_hfront = hf[7:0]; cfg_hsw = hw[5:0]; cfg_hback = hb[7:0];
        cfg_vfront = vf[7:0]; cfg_vsw = vw[5:0]; cfg_vback = vb[7:0];
        cfg_hpol = hp; cfg_vpol = vp; cfg_clkpol = cp; cfg_sclk_run = run;
    endtask

    task automatic clear_stats();
        bof_q.delete(); eof_n = 0; oe_n = 0; hs_n = 0; vs_tog = 0;
    endtask

    initial begin
        // scenario A: divide by 4, inverted syncs, shift clock parked in frame sync
        setcfg(3, 1, 2, 0, 1, 0, 0, 2, 0, 1'b1, 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R9 reset x", pix_x, 0);
        chk("R9 reset y", pix_y, 0);
        chk("R9 reset oe", lcd_oe, 1);
        chk("R9 reset bof", frame_start, 0);
        chk("R9 reset hsync idle", lcd_hsync, 1);
        rst_n = 1'b1; mon_on = 1'b1;
        clear_stats();
        repeat (4 * 272) @(negedge clk);
        chk("R8 bof count A", bof_q.size(), 4);
        chk("R8 eof count A", eof_n, 4);
        if (bof_q.size() >= 3) chk("R1 frame period div3", bof_q[2] - bof_q[1], 272);
        chk("R6 parked sclk edges", vs_tog, 0);

        // scenario B: divide by 2, clock free-running through frame sync
        setcfg(1, 1, 3, 3, 2, 1, 1, 1, 1, 1'b0, 1'b0, 1'b0, 1'b1);
        clear_stats();
        repeat (4 * 264) @(negedge clk);
        if (bof_q.size() >= 3) chk("R1 frame period div1", bof_q[2] - bof_q[1], 264);
        else chk("R8 bof count B", bof_q.size(), 3);
        chk("R6 free sclk edges", (vs_tog > 0) ? 1 : 0, 1);

        // scenario C: odd divider, every blanking region zero length
        setcfg(2, 2, 2, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        clear_stats();
        repeat (4 * 192) @(negedge clk);
        if (bof_q.size() >= 3) chk("R4 frame period back-to-back", bof_q[2] - bof_q[1], 192);
        else chk("R8 bof count C", bof_q.size(), 3);
        chk("R10 no hsync when width zero", hs_n, 0);

        // scenario D: zero height gives no visible output
        setcfg(0, 1, 0, 1, 1, 1, 2, 1, 1, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (100) @(negedge clk);
        clear_stats();
        repeat (300) @(negedge clk);
        chk("R7 no oe at zero height", oe_n, 0);
        chk("R8 no bof at zero height", bof_q.size(), 0);

        // scenario E: shrink the line while the position is past the new total
        setcfg(0, 4, 4, 2, 2, 2, 1, 1, 1, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (pix_x == 10'd50) break;
        end
        chk("R7 reached column 50", pix_x, 50);
        cfg_xmax16 = 6'd1;
        @(negedge clk);
        chk("R10 wrap after shrink", pix_x, 0);
        repeat (200) @(negedge clk);

        // scenario F: everything zero, positions pinned
        setcfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        clear_stats();
        repeat (50) @(negedge clk);
        chk("R10 zero total oe", oe_n, 0);
        chk("R10 zero total x", pix_x, 0);
        chk("R10 zero total y", pix_y, 0);
        chk("R10 zero total hsync", hs_n, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule